// File: doc/BRIEF.md
# Byte-Packing Transfer FIFO with Threshold Flag

This block sits between a memory-mapped data register and a serial command sequencer during indirect transfers. On the host side a single access moves one, two or four bytes in one clock: writes are split into bytes and stored lowest byte first, and reads assemble bytes into the low end of the returned word. On the serial side the sequencer pushes or pops one byte per cycle.

The block reports how many bytes it currently holds and raises a threshold flag. In read mode (`dir_rd` high) the flag means that enough bytes are waiting to be collected. In write mode it means that enough free space exists for the host to write more. When enabled, a DMA request output follows the flag. A host access that cannot complete holds `host_ready` low instead of losing or inventing data. A flush input clears the FIFO to empty.

Top module: `xfer_byte_fifo`

## Requirements
- R1: After reset `level` is 0. With `dir_rd`=0 `thr_flag` is 1, and with `dir_rd`=1 it is 0. A serial pop is refused (`ser_pop_ack`=0).
- R2: A host write with `host_size` 0, 1 or 2 stores 1, 2 or 4 bytes. Size 3 acts as 2 and stores 4 bytes. The bytes are taken from `host_wdata[7:0]` upward and leave the serial side in that order.
- R3: A host read with size 0, 1 or 2 returns 1, 2 or 4 bytes. The oldest byte is in `host_rdata[7:0]` and later bytes are in the bits above it. All bits above the bytes read are 0.
- R4: `level` equals the number of bytes held (0 to 32). It takes its new value in the cycle after an accepted access.
- R5: A host write that needs more free space than exists keeps `host_ready` at 0 and stores nothing. It completes once serial pops have made enough room, and its bytes are then delivered intact.
- R6: A host read that asks for more bytes than are held keeps `host_ready` at 0 and removes nothing.
- R7: A serial push is acknowledged only when the FIFO is not full, and a serial pop only when it is not empty. When the host writes in the same cycle as a serial push, the host write wins and the push is refused. The same rule applies to a host read and a serial pop.
- R8: In read mode `thr_flag` is 1 exactly when `level` is at least `thr_cfg`+1.
- R9: In write mode `thr_flag` is 1 exactly when the free space (32 − `level`) is at least `thr_cfg`+1.
- R10: `dma_req` equals `thr_flag` while `dma_en` is 1, and it is 0 while `dma_en` is 0.
- R11: A cycle with `flush` high refuses every host and serial access in that cycle. In the next cycle `level` is 0. Bytes stored after the flush come out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_rd | input | 1 | 1 = read mode (flag counts held bytes), 0 = write mode (flag counts free space) |
| thr_cfg | input | 5 | Threshold minus one |
| dma_en | input | 1 | Lets the flag drive `dma_req` |
| flush | input | 1 | Empties the FIFO |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| host_wdata | input | 32 | Host write data, first byte in bits 7:0 |
| host_ready | output | 1 | Access completes at this clock edge |
| host_rdata | output | 32 | Host read data, valid while `host_ready` is high on a read |
| ser_push | input | 1 | Sequencer pushes one byte |
| ser_wdata | input | 8 | Byte to push |
| ser_push_ack | output | 1 | Push accepted this cycle |
| ser_pop | input | 1 | Sequencer pops one byte |
| ser_rdata | output | 8 | Oldest byte held |
| ser_pop_ack | output | 1 | Pop accepted this cycle |
| level | output | 6 | Bytes held |
| thr_flag | output | 1 | Threshold flag |
| dma_req | output | 1 | DMA request |

## Verification
`host_ready`, the acknowledges, `host_rdata` and `ser_rdata` are combinational and belong to the cycle in which the request is presented. The bench drives on the falling edge and samples them one nanosecond later, before the next rising edge. `level`, `thr_flag` and `dma_req` change only after the rising edge that commits an access, so the bench checks them at the next falling edge. Stall checks sample `host_ready` in every waiting cycle, and each one is compared against the level that the earlier pops should have produced.

// File: rtl/xdf_pkg.sv
// Package: shared access-size encoding and byte counts for the transfer FIFO.
// Assumes the host data path is four bytes wide.
package xdf_pkg;

    localparam int HOST_BYTES = 4;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WIDE = 2'd3
    } acc_size_e;

    // Number of bytes an access of the given size moves.
    function automatic logic [2:0] acc_bytes(input acc_size_e s);
        case (s)
            ACC_BYTE: acc_bytes = 3'd1;
            ACC_HALF: acc_bytes = 3'd2;
            default:  acc_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/xdf_host_if.sv
// Host access gate: decodes the access size and decides whether the
// request can finish this cycle, given the fill level.
// Assumes one host access per cycle and DEPTH >= 4.
module xdf_host_if
    import xdf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          host_valid,
    input  logic          host_write,
    input  logic [1:0]    host_size,
    input  logic [LW-1:0] level,
    input  logic          flush,
    output logic          host_ready,
    output logic          h_wr,
    output logic          h_rd,
    output logic [2:0]    h_n
);

    logic [LW-1:0] free_sp;
    logic          room;

    // Size decode and space/data availability check.
    always_comb begin
        h_n     = acc_bytes(acc_size_e'(host_size));
        free_sp = LW'(DEPTH) - level;
        room    = host_write ? (free_sp >= LW'(h_n)) : (level >= LW'(h_n));
    end

    // All-or-nothing acceptance; flush refuses everything.
    always_comb begin
        host_ready = host_valid && !flush && room;
        h_wr       = host_ready && host_write;
        h_rd       = host_ready && !host_write;
    end

endmodule

// File: rtl/xdf_store.sv
// Byte storage: circular buffer of DEPTH bytes with multi-byte host write
// and read ports plus single-byte serial ports, and the fill counter.
// Assumes DEPTH is a power of two >= 4, the caller never writes on both
// push ports or reads on both pop ports in one cycle, and checks room.
module xdf_store #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [2:0]    h_n,
    input  logic [31:0]   h_wdata,
    input  logic          s_push,
    input  logic [7:0]    s_wdata,
    input  logic          s_pop,
    output logic [LW-1:0] level,
    output logic [31:0]   h_rdata,
    output logic [7:0]    s_rdata
);

    localparam int MW = DEPTH * 8;

    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] lvl;
    logic [MW-1:0] mem_flat;
    logic [AW-1:0] rd_idx;
    logic [LW-1:0] add_n, sub_n;

    // One storage byte per entry, written by offset from the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [AW-1:0] ofs;
        logic          hit_h, hit_s;
        logic [7:0]    q;

        assign ofs   = AW'(i) - wptr;
        assign hit_h = h_wr && (int'(ofs) < int'(h_n));
        assign hit_s = s_push && (ofs == '0);

        // Capture the host byte lane or the serial byte aimed at this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)     q <= '0;
            else if (hit_h) q <= h_wdata[{ofs[1:0], 3'b000} +: 8];
            else if (hit_s) q <= s_wdata;
        end

        assign mem_flat[i*8 +: 8] = q;
    end

    // Host read lanes: oldest byte lowest, lanes beyond the size forced to 0.
    always_comb begin
        h_rdata = '0;
        rd_idx  = rptr;
        for (int k = 0; k < 4; k++) begin
            rd_idx = rptr + AW'(k);
            if (k < int'(h_n)) h_rdata[k*8 +: 8] = mem_flat[{rd_idx, 3'b000} +: 8];
        end
    end

    // Serial side sees the oldest byte.
    assign s_rdata = mem_flat[{rptr, 3'b000} +: 8];

    // Byte counts entering and leaving this cycle.
    always_comb begin
        add_n = (h_wr ? LW'(h_n) : '0) + (s_push ? LW'(1) : '0);
        sub_n = (h_rd ? LW'(h_n) : '0) + (s_pop  ? LW'(1) : '0);
    end

    // Pointer and fill counter update; flush returns to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            lvl  <= '0;
        end else begin
            wptr <= wptr + AW'(add_n);
            rptr <= rptr + AW'(sub_n);
            lvl  <= lvl + add_n - sub_n;
        end
    end

    assign level = lvl;

    // R4: the counter never leaves 0..DEPTH.
    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl) <= DEPTH);

    // R5: an accepted host write always fits.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr |-> (int'(lvl) + int'(h_n) <= DEPTH));

    // R6: an accepted host read never takes more than is held.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd |-> (int'(lvl) >= int'(h_n)));

    // R7: serial push only below full, serial pop only above empty.
    p_ser_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_push |-> (int'(lvl) < DEPTH));
    p_ser_pop_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_pop |-> (lvl != '0));

    // R11: flush leaves the store empty on the next cycle.
    p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (lvl == '0));

endmodule

// File: rtl/xdf_thresh.sv
// Threshold evaluation: compares held bytes (read mode) or free space
// (write mode) with threshold+1 and gates the result into a DMA request.
// Assumes the threshold field is wide enough to encode DEPTH-1.
module xdf_thresh #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          dir_rd,
    input  logic [TW-1:0] thr_cfg,
    input  logic          dma_en,
    input  logic [LW-1:0] level,
    output logic          thr_flag,
    output logic          dma_req
);

    logic [LW-1:0] need, avail;

    // Direction-dependent quantity against the programmed threshold.
    always_comb begin
        need     = LW'(thr_cfg) + LW'(1);
        avail    = dir_rd ? level : (LW'(DEPTH) - level);
        thr_flag = avail >= need;
        dma_req  = thr_flag && dma_en;
    end

endmodule

// File: rtl/xfer_byte_fifo.sv
// Transfer FIFO top: host packing port, serial byte ports, fill level and
// threshold/DMA flag. Host accesses take priority over a serial access in
// the same direction; a flush cycle refuses all accesses.
// Assumes DEPTH is a power of two >= 4.
module xfer_byte_fifo #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dir_rd,
    input  logic [$clog2(DEPTH)-1:0]   thr_cfg,
    input  logic                       dma_en,
    input  logic                       flush,
    input  logic                       host_valid,
    input  logic                       host_write,
    input  logic [1:0]                 host_size,
    input  logic [31:0]                host_wdata,
    output logic                       host_ready,
    output logic [31:0]                host_rdata,
    input  logic                       ser_push,
    input  logic [7:0]                 ser_wdata,
    output logic                       ser_push_ack,
    input  logic                       ser_pop,
    output logic [7:0]                 ser_rdata,
    output logic                       ser_pop_ack,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       thr_flag,
    output logic                       dma_req
);

    localparam int LW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);
    localparam int TW = $clog2(DEPTH);

    logic          h_wr, h_rd;
    logic [2:0]    h_n;
    logic [LW-1:0] lvl;

    xdf_host_if #(.DEPTH(DEPTH), .LW(LW)) u_host (
        .host_valid (host_valid),
        .host_write (host_write),
        .host_size  (host_size),
        .level      (lvl),
        .flush      (flush),
        .host_ready (host_ready),
        .h_wr       (h_wr),
        .h_rd       (h_rd),
        .h_n        (h_n)
    );

    // Serial arbitration: host wins its direction, flush blocks all.
    always_comb begin
        ser_push_ack = ser_push && !flush && !h_wr && (int'(lvl) < DEPTH);
        ser_pop_ack  = ser_pop  && !flush && !h_rd && (lvl != '0);
    end

    xdf_store #(.DEPTH(DEPTH), .LW(LW), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .h_wr    (h_wr),
        .h_rd    (h_rd),
        .h_n     (h_n),
        .h_wdata (host_wdata),
        .s_push  (ser_push_ack),
        .s_wdata (ser_wdata),
        .s_pop   (ser_pop_ack),
        .level   (lvl),
        .h_rdata (host_rdata),
        .s_rdata (ser_rdata)
    );

    xdf_thresh #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_thr (
        .dir_rd   (dir_rd),
        .thr_cfg  (thr_cfg),
        .dma_en   (dma_en),
        .level    (lvl),
        .thr_flag (thr_flag),
        .dma_req  (dma_req)
    );

    assign level = lvl;

    // R8: an empty FIFO never signals data ready in read mode.
    p_rd_flag_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rd && lvl == '0) |-> !thr_flag);

    // R9: an empty FIFO always offers space in write mode.
    p_wr_flag_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rd && lvl == '0) |-> thr_flag);

    // R10: no DMA request while DMA is disabled.
    p_dma_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    // R11: after a flush the read-mode flag is low and the write-mode flag high.
    p_flush_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (thr_flag == !dir_rd));

    // R7: a host write and a serial push never both land in one cycle.
    p_push_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_wr && ser_push_ack));

endmodule

// File: tb/tb_xfer_byte_fifo.sv
`timescale 1ns/100ps
module tb_xfer_byte_fifo;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dir_rd, dma_en, flush;
    logic [4:0]  thr_cfg;
    logic        host_valid, host_write, host_ready;
    logic [1:0]  host_size;
    logic [31:0] host_wdata, host_rdata;
    logic        ser_push, ser_push_ack, ser_pop, ser_pop_ack;
    logic [7:0]  ser_wdata, ser_rdata;
    logic [5:0]  level;
    logic        thr_flag, dma_req;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    xfer_byte_fifo #(.DEPTH(32)) dut (.*);

    typedef struct packed {
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [2:0]  n;
        logic [31:0] exp;   // expected bytes, first out in [7:0]
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd0, 32'hDEADBE5A, 3'd1, 32'h0000005A},
        '{2'd1, 32'h1234A7C3, 3'd2, 32'h0000A7C3},
        '{2'd2, 32'h89ABCDEF, 3'd4, 32'h89ABCDEF},
        '{2'd3, 32'h0F1E2D3C, 3'd4, 32'h0F1E2D3C},
        '{2'd1, 32'hFFFF0001, 3'd2, 32'h00000001},
        '{2'd0, 32'h00000080, 3'd1, 32'h00000080}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Host access from a falling edge; optionally waits for acceptance.
    task automatic host_op(input logic w, input logic [1:0] sz, input logic [31:0] d,
                           input bit persist, output logic rdy, output logic [31:0] rd);
        int n = 0;
        host_valid = 1'b1; host_write = w; host_size = sz; host_wdata = d;
        #1;
        while (persist && !host_ready && n < 40) begin
            @(negedge clk); #1; n++;
        end
        rdy = host_ready; rd = host_rdata;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    // One serial push (push=1) or pop (push=0) attempt.
    task automatic ser_op(input logic push, input logic [7:0] d,
                          output logic ack, output logic [7:0] q);
        ser_push = push; ser_pop = !push; ser_wdata = d;
        #1;
        ack = push ? ser_push_ack : ser_pop_ack;
        q   = ser_rdata;
        @(negedge clk);
        ser_push = 1'b0; ser_pop = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic        rdy, ack;
        logic [31:0] rd;
        logic [7:0]  q;

        rst_n = 1'b0; dir_rd = 1'b0; dma_en = 1'b0; flush = 1'b0; thr_cfg = 5'd3;
        host_valid = 1'b0; host_write = 1'b0; host_size = 2'd0; host_wdata = '0;
        ser_push = 1'b0; ser_pop = 1'b0; ser_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 level", 32'(level), 32'd0);
        #1 check("R1 wr-mode flag", 32'(thr_flag), 32'd1);
        dir_rd = 1'b1; #1;
        check("R1 rd-mode flag", 32'(thr_flag), 32'd0);
        dir_rd = 1'b0;
        ser_op(1'b0, 8'h00, ack, q);
        check("R1 pop refused", 32'(ack), 32'd0);

        // R2/R4 table: host write, level, serial byte order
        for (int v = 0; v < 6; v++) begin
            host_op(1'b1, VEC[v].sz, VEC[v].wd, 1'b1, rdy, rd);
            check("R2 write accepted", 32'(rdy), 32'd1);
            check("R4 level after write", 32'(level), 32'(VEC[v].n));
            for (int b = 0; b < int'(VEC[v].n); b++) begin
                ser_op(1'b0, 8'h00, ack, q);
                check("R2 byte order", {23'd0, ack, q}, {23'd0, 1'b1, VEC[v].exp[b*8 +: 8]});
            end
            check("R4 level drained", 32'(level), 32'd0);
        end

        // R5 stall on full, completes after pops, data intact
        for (int w = 0; w < 8; w++) host_op(1'b1, 2'd2, 32'h03020100 + 32'h04040404 * w, 1'b1, rdy, rd);
        check("R4 full level", 32'(level), 32'd32);
        ser_push = 1'b1; ser_wdata = 8'hEE; #1;
        check("R7 push refused full", 32'(ser_push_ack), 32'd0);
        ser_push = 1'b0;
        host_valid = 1'b1; host_write = 1'b1; host_size = 2'd2; host_wdata = 32'hCAFEF00D;
        for (int c = 0; c < 4; c++) begin
            ser_pop = 1'b1; #1;
            check("R5 stalled while short of space", 32'(host_ready), 32'd0);
            check("R5 level during stall", 32'(level), 32'(32 - c));
            @(negedge clk);
        end
        ser_pop = 1'b0; #1;
        check("R5 write completes", 32'(host_ready), 32'd1);
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
        check("R5 level after late write", 32'(level), 32'd32);
        for (int b = 0; b < 28; b++) ser_op(1'b0, 8'h00, ack, q);
        for (int b = 0; b < 4; b++) begin
            ser_op(1'b0, 8'h00, ack, q);
            check("R5 stalled data intact", 32'(q), 32'(8'(32'hCAFEF00D >> (8 * b))));
        end

        // R3/R6 read mode: serial fills, host drains
        dir_rd = 1'b1;
        for (int b = 0; b < 7; b++) ser_op(1'b1, 8'h10 + 8'(b), ack, q);
        check("R4 level after pushes", 32'(level), 32'd7);
        host_op(1'b0, 2'd2, '0, 1'b0, rdy, rd);
        check("R3 word read", rd, 32'h13121110);
        host_op(1'b0, 2'd1, '0, 1'b0, rdy, rd);
        check("R3 half read upper zero", rd, 32'h00001514);
        host_op(1'b0, 2'd2, '0, 1'b0, rdy, rd);
        check("R6 word read stalls at 1 byte", 32'(rdy), 32'd0);
        check("R6 nothing removed", 32'(level), 32'd1);
        host_op(1'b0, 2'd0, '0, 1'b0, rdy, rd);
        check("R3 byte read", {rd[31:1], rdy}, {32'h00000016 >> 1, 1'b1});
        host_op(1'b0, 2'd0, '0, 1'b0, rdy, rd);
        check("R6 byte read stalls empty", 32'(rdy), 32'd0);

        // R7 host write wins over serial push
        ser_push = 1'b1; ser_wdata = 8'h99;
        host_op(1'b1, 2'd0, 32'h00000042, 1'b0, rdy, rd);
        ser_push = 1'b0;
        check("R7 host write accepted", 32'(rdy), 32'd1);
        check("R7 level only host byte", 32'(level), 32'd1);
        host_op(1'b0, 2'd0, '0, 1'b0, rdy, rd);
        check("R7 host byte stored", rd, 32'h00000042);

        // R8 read-mode flag, threshold 3 => 4 bytes
        for (int b = 0; b < 3; b++) ser_op(1'b1, 8'(b), ack, q);
        check("R8 flag low at 3", 32'(thr_flag), 32'd0);
        ser_op(1'b1, 8'h03, ack, q);
        check("R8 flag high at 4", 32'(thr_flag), 32'd1);
        do_flush();

        // R9/R10 write mode flag and DMA gate
        dir_rd = 1'b0;
        for (int w = 0; w < 7; w++) host_op(1'b1, 2'd2, 32'h0, 1'b1, rdy, rd);
        #1 check("R9 flag high at free 4", 32'(thr_flag), 32'd1);
        check("R10 dma off", 32'(dma_req), 32'd0);
        dma_en = 1'b1; #1;
        check("R10 dma follows flag", 32'(dma_req), 32'd1);
        @(negedge clk);
        host_op(1'b1, 2'd0, 32'h0, 1'b1, rdy, rd);
        check("R9 flag low at free 3", 32'(thr_flag), 32'd0);
        check("R10 dma low with flag", 32'(dma_req), 32'd0);
        dma_en = 1'b0;

        // R11 flush refuses access, empties, restarts order
        flush = 1'b1;
        host_valid = 1'b1; host_write = 1'b1; host_size = 2'd0; host_wdata = 32'h11;
        #1 check("R11 host refused in flush cycle", 32'(host_ready), 32'd0);
        @(negedge clk);
        flush = 1'b0; host_valid = 1'b0; host_write = 1'b0;
        check("R11 level empty", 32'(level), 32'd0);
        check("R11 write flag high", 32'(thr_flag), 32'd1);
        host_op(1'b1, 2'd0, 32'h00000077, 1'b1, rdy, rd);
        ser_op(1'b0, 8'h00, ack, q);
        check("R11 first byte after flush", {23'd0, ack, q}, {23'd0, 1'b1, 8'h77});

        // R8/R9 threshold 31 => 32 bytes
        thr_cfg = 5'd31; #1;
        check("R9 flag at empty thr 31", 32'(thr_flag), 32'd1);
        dir_rd = 1'b1;
        for (int w = 0; w < 7; w++) host_op(1'b1, 2'd2, 32'h0, 1'b1, rdy, rd);
        for (int b = 0; b < 3; b++) host_op(1'b1, 2'd0, 32'h0, 1'b1, rdy, rd);
        check("R8 flag low at 31", 32'(thr_flag), 32'd0);
        ser_op(1'b1, 8'h5, ack, q);
        check("R8 flag high at 32", {31'd0, thr_flag}, 32'd1);
        check("R4 level full", 32'(level), 32'd32);
        do_flush();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule